// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller with Peripheral Takeover

This block controls an 8-bit general-purpose I/O port on a small microcontroller bus. Each pin has a direction bit and an output latch bit. The block drives a value and an output-enable toward each pad cell, and samples the pad input through a two-flop synchronizer. The synchronized pin levels feed CPU reads and the peripheral input path.

A peripheral can claim any pin with its own output-enable and output value. Pins 3 to 5 can each be switched from push-pull to open-drain. An external stop-mode signal, combined with a standby high-impedance control, releases every pin.

The CPU side is a simple strobe interface with a combinational read path. A qualifier on reads selects read-modify-write behaviour: such a read returns the output latch instead of the pin levels. This keeps bit-set and bit-clear sequences correct on ports that mix inputs and outputs.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and after it is released, every pad output-enable is 0, and the direction register (address 1) and the mode register (address 2) read 0.
- R2: When a pin's direction bit is 1 and no peripheral claims it, the pin is enabled and drives its output latch bit (push-pull mode).
- R3: A write to the data register (address 0) updates the output latch whatever the direction bits are, so a value can be preloaded while the pins are inputs.
- R4: A normal read of address 0 (`rd_rmw` = 0) returns the synchronized pin levels.
- R5: A read of address 0 with `rd_rmw` = 1 returns the output latch for every bit, whatever the direction bits are.
- R6: When `per_oe[i]` is 1, pad i is enabled and drives `per_out[i]`, even when its direction bit is 0.
- R7: While a peripheral drives a pin, a normal read of address 0 returns that pin's level.
- R8: `per_in` always equals the pad input delayed by the two synchronizer stages, whatever the direction and peripheral settings.
- R9: Address 2 holds one open-drain mode bit per pin for pins 3, 4 and 5, at bit positions 3 to 5. All other bits are ignored on write and read as 0. In open-drain mode a driven 1 turns the pad enable off, and only a 0 is actively driven.
- R10: When `stop_mode` and `standby_hiz` are both 1, every pad output-enable is 0, regardless of direction bits and peripheral enables. When either signal is 0, the pins behave normally.
- R11: A register write takes effect on the rising clock edge that samples `wr_en` high. Before that edge, reads return the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 data, 1 direction, 2 open-drain mode |
| wdata | input | 8 | Write data |
| rd_rmw | input | 1 | Read-modify-write qualifier for data register reads |
| rdata | output | 8 | Combinational read data for `addr` |
| per_oe | input | 8 | Per-pin peripheral output-enable |
| per_out | input | 8 | Per-pin peripheral output value |
| per_in | output | 8 | Synchronized pin levels toward peripherals |
| stop_mode | input | 1 | Stop mode active |
| standby_hiz | input | 1 | Standby control: release all pins while stopped |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output-enables |

## Verification
A corrupted direction or mode bit appears on `pad_oe` in the same cycle as the bad state. A corrupted output latch appears on `pad_out`, or on a read-modify-write read, at once. A fault in the synchronizer shows up as a pin level arriving on `rdata` or `per_in` one cycle early or late. The bench waits for that fixed two-edge delay before it compares. A write that lands one edge early or late shows up on the read port in the cycle around the strobe.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_MODE = 2'd2
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= din;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] latch,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] od_mode,
  input  logic [WIDTH-1:0] per_oe,
  input  logic [WIDTH-1:0] per_out,
  input  logic             hiz_all,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic drv_val;
    logic want_drive;
    logic od_release;

    always_comb begin
      drv_val    = per_oe[i] ? per_out[i] : latch[i];
      want_drive = per_oe[i] | dir[i];
      od_release = od_mode[i] & drv_val;
      pad_out[i] = drv_val;
      pad_oe[i]  = want_drive & ~od_release & ~hiz_all;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH       = 8,
  parameter int OD_LO       = 3,
  parameter int OD_HI       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [gpio_pkg::ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       rd_rmw,
  output logic [WIDTH-1:0]           rdata,
  input  logic [WIDTH-1:0]           per_oe,
  input  logic [WIDTH-1:0]           per_out,
  output logic [WIDTH-1:0]           per_in,
  input  logic                       stop_mode,
  input  logic                       standby_hiz,
  input  logic [WIDTH-1:0]           pad_in,
  output logic [WIDTH-1:0]           pad_out,
  output logic [WIDTH-1:0]           pad_oe
);
  import gpio_pkg::*;

  function automatic logic [WIDTH-1:0] make_od_mask();
    logic [WIDTH-1:0] m;
    m = '0;
    for (int i = OD_LO; i <= OD_HI; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [WIDTH-1:0] OD_MASK = make_od_mask();

  logic             rst_int_n;
  logic [WIDTH-1:0] data_q, data_d;
  logic [WIDTH-1:0] dir_q, dir_d;
  logic [WIDTH-1:0] od_q, od_d;
  logic [WIDTH-1:0] pin_sync;
  logic             data_we, dir_we, mode_we;

  gpio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk  (clk),
    .din  (pad_in),
    .dout (pin_sync)
  );

  // Write decode and next-state
  always_comb begin
    data_we = wr_en && (addr == REG_DATA);
    dir_we  = wr_en && (addr == REG_DIR);
    mode_we = wr_en && (addr == REG_MODE);
    data_d  = data_we ? wdata : data_q;
    dir_d   = dir_we  ? wdata : dir_q;
    od_d    = mode_we ? (wdata & OD_MASK) : od_q;
  end

  // Output latch: not reset
  always_ff @(posedge clk) begin
    if (data_we) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dir_q <= '0;
      od_q  <= '0;
    end else begin
      if (dir_we)  dir_q <= dir_d;
      if (mode_we) od_q  <= od_d;
    end
  end

  // Read mux
  always_comb begin
    case (addr)
      REG_DATA: rdata = rd_rmw ? data_q : pin_sync;
      REG_DIR:  rdata = dir_q;
      REG_MODE: rdata = od_q;
      default:  rdata = '0;
    endcase
  end

  assign per_in = pin_sync;

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad_ctrl (
    .latch   (data_q),
    .dir     (dir_q),
    .od_mode (od_q),
    .per_oe  (per_oe),
    .per_out (per_out),
    .hiz_all (stop_mode & standby_hiz),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 8,
  parameter int OD_LO = 3
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] data_q,
  input logic [WIDTH-1:0] od_q,
  input logic [WIDTH-1:0] per_oe,
  input logic [WIDTH-1:0] per_out,
  input logic [WIDTH-1:0] per_in,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic             stop_mode,
  input logic             standby_hiz
);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stop_mode && standby_hiz) |-> (pad_oe == '0));

  // R6
  per_takeover_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (per_oe[0] && !(stop_mode && standby_hiz)) |-> (pad_oe[0] && pad_out[0] == per_out[0]));

  // R2
  dir_drive_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dir_q[0] && !per_oe[0] && !(stop_mode && standby_hiz)) |-> (pad_oe[0] && pad_out[0] == data_q[0]));

  // R9
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (od_q[OD_LO] && pad_oe[OD_LO]) |-> !pad_out[OD_LO]);

  // R8
  per_in_delay_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    per_in == $past(pad_in, 2));

  // R11
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && addr == 2'd1) |=> (dir_q == $past(wdata)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .OD_LO(OD_LO)) u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .wr_en       (wr_en),
  .addr        (addr),
  .wdata       (wdata),
  .dir_q       (dir_q),
  .data_q      (data_q),
  .od_q        (od_q),
  .per_oe      (per_oe),
  .per_out     (per_out),
  .per_in      (per_in),
  .pad_in      (pad_in),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .stop_mode   (stop_mode),
  .standby_hiz (standby_hiz)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic       rd_rmw;
  logic [7:0] rdata;
  logic [7:0] per_oe, per_out, per_in;
  logic       stop_mode, standby_hiz;
  logic [7:0] pad_in, pad_out, pad_oe;
  logic [7:0] ext;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] mask;
    logic [7:0] exp;
  } item_t;

  item_t sb_q[$];

  initial clk = 0;
  always #5 clk = ~clk;

  // Pad model: the driven value wins, otherwise the external level
  always_comb begin
    for (int i = 0; i < 8; i++) pad_in[i] = pad_oe[i] ? pad_out[i] : ext[i];
  end

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_rmw(rd_rmw), .rdata(rdata), .per_oe(per_oe), .per_out(per_out),
    .per_in(per_in), .stop_mode(stop_mode), .standby_hiz(standby_hiz),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        0: act = rdata;
        1: act = pad_oe;
        2: act = pad_out;
        default: act = per_in;
      endcase
      checks++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%02h expected=%02h mask=%02h",
                 it.req, it.sel, act & it.mask, it.exp & it.mask, it.mask);
      end
    end
  end

  task automatic expect_out(string req, int sel, logic [7:0] mask, logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.mask = mask; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic expect_rd(string req, logic [1:0] a, logic rmw, logic [7:0] exp);
    addr = a; rd_rmw = rmw;
    expect_out(req, 0, 8'hFF, exp);
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 0; wr_en = 0; addr = 0; wdata = 0; rd_rmw = 0;
    per_oe = 0; per_out = 0; stop_mode = 0; standby_hiz = 0; ext = 0;
    repeat (5) @(posedge clk);
    #1;
    // R1 during reset
    expect_out("R1", 1, 8'hFF, 8'h00);
    step();
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;

    // R1 after release
    expect_out("R1", 1, 8'hFF, 8'h00);
    expect_rd("R1", 2'd1, 0, 8'h00);
    expect_rd("R1", 2'd2, 0, 8'h00);

    // R3 preload the latch while all pins are inputs
    wr_reg(2'd0, 8'h3C);
    expect_rd("R3", 2'd0, 1, 8'h3C);
    expect_out("R3", 1, 8'hFF, 8'h00);
    step();

    // R11 write timing on the direction register
    wr_en = 1; addr = 2'd1; wdata = 8'hFF; rd_rmw = 0;
    expect_out("R11", 0, 8'hFF, 8'h00);
    step();
    wr_en = 0;
    expect_out("R11", 0, 8'hFF, 8'hFF);
    step();

    // R2 outputs drive the latch
    expect_out("R2", 1, 8'hFF, 8'hFF);
    expect_out("R2", 2, 8'hFF, 8'h3C);
    step();
    wr_reg(2'd0, 8'hA5);
    expect_out("R2", 2, 8'hFF, 8'hA5);
    step();

    // R4 normal read returns pins
    wr_reg(2'd1, 8'h00);
    ext = 8'h5A;
    settle();
    expect_rd("R4", 2'd0, 0, 8'h5A);

    // R5 mixed directions, RMW read returns latch
    wr_reg(2'd0, 8'hC3);
    wr_reg(2'd1, 8'h0F);
    ext = 8'h55;
    settle();
    expect_rd("R5", 2'd0, 0, 8'h53);
    expect_rd("R5", 2'd0, 1, 8'hC3);

    // R6 peripheral takeover of inputs
    wr_reg(2'd1, 8'h00);
    per_oe = 8'h81; per_out = 8'h01; ext = 8'h00;
    #1;
    expect_out("R6", 1, 8'hFF, 8'h81);
    expect_out("R6", 2, 8'h81, 8'h01);
    settle();
    // R7 pin read sees the peripheral value
    expect_rd("R7", 2'd0, 0, 8'h01);
    // R8 peripheral input path
    expect_out("R8", 3, 8'hFF, 8'h01);
    step();
    per_oe = 0; per_out = 0;
    ext = 8'hE7;
    settle();
    expect_out("R8", 3, 8'hFF, 8'hE7);
    step();

    // R9 open-drain mode bits
    wr_reg(2'd2, 8'hFF);
    expect_rd("R9", 2'd2, 0, 8'h38);
    wr_reg(2'd0, 8'hFF);
    wr_reg(2'd1, 8'hFF);
    expect_out("R9", 1, 8'hFF, 8'hC7);
    step();
    wr_reg(2'd0, 8'h00);
    expect_out("R9", 1, 8'hFF, 8'hFF);
    expect_out("R9", 2, 8'hFF, 8'h00);
    step();

    // R10 standby release
    stop_mode = 1; standby_hiz = 0; #1;
    expect_out("R10", 1, 8'hFF, 8'hFF);
    step();
    standby_hiz = 1; per_oe = 8'hFF; #1;
    expect_out("R10", 1, 8'hFF, 8'h00);
    step();
    stop_mode = 0; per_oe = 8'h00; #1;
    expect_out("R10", 1, 8'hFF, 8'hFF);
    step();

    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule